// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block holds the debug breakpoint state of a processor core and watches every memory access the core presents. It keeps four linear breakpoint addresses, a control word that gives each address slot its enables, access type and length, and a sticky status word that records which slots fired and whether a single-step trap was taken. Software reads and writes all six registers through a plain synchronous register port.

On each clock where an access is strobed valid, every enabled slot compares the access type and the access's byte range against its own aligned range. When any slot hits, a one-cycle debug trap pulse is raised and the status bits of every slot that hit are set on the same edge. A resume input masks instruction-fetch breakpoints, so execution can continue from an address that just trapped. A separate tracker raises a single-step trap at the end of each instruction that began with the trap flag already set. The instruction that sets the flag does not trap.

Top module: `bkpt_match_unit`

## Requirements
- R1: After a synchronous active-low reset, the four address registers and the control register read 0, the status register reads 0xFFFF0000, and both trap outputs are low.
- R2: Register select 0 to 3 picks address slot 0 to 3, select 4 the status word and select 5 the control word. A write stores `reg_wdata` on the clock edge. The read data shows the selected register in the same cycle, and selects 6 and 7 read 0.
- R3: Slot n is enabled when either control bit 2n or control bit 2n+1 is set. With both bits clear, the slot never matches.
- R4: The 2-bit type field of slot n sits at control bits 17+4n:16+4n. Type 00 matches only fetches, 01 only data writes, and 11 data reads or writes but not fetches. Access kind codes are 00 fetch, 01 read, 10 write and 11 port.
- R5: Type 10 never matches while `dbg_ext` is low. While it is high, type 10 matches port accesses only, and no other type matches a port access.
- R6: The 2-bit length field of slot n sits at control bits 19+4n:18+4n. Codes 00, 01 and 11 cover 1, 2 and 4 bytes, starting at the slot address with its low 0, 1 or 2 bits cleared. Code 10 never matches.
- R7: An access covers 1, 2 or 4 bytes from `acc_addr` for `acc_size` 00, 01 and 1x. It matches when that range shares at least one byte with the slot's range.
- R8: No slot matches in a cycle where `acc_valid` is low.
- R9: When any slot matches, `bp_trap` is high for exactly the cycle after the sampling edge. On that same edge, status bit n is set for every slot n that matched.
- R10: Status bits are sticky. Hardware only sets them, and a software write to the status register replaces them. A hit on the same edge as a write still leaves its bit set.
- R11: While `resume_flag` is high, type-00 (fetch) slots do not match. Data slots are unaffected.
- R12: At an `insn_retire` pulse, a single-step trap is raised if the trap flag was high at the previous retire. The trap appears on `step_trap` for one cycle after that edge and sets status bit 14 on the same edge.
- R13: Status bits 31 to 16 always read 1. The status bits other than 3:0 and 14 read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | Access kind: fetch, read, write, port |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 2 | Access size code |
| dbg_ext | input | 1 | Enables the port type code |
| resume_flag | input | 1 | Masks fetch breakpoints |
| trap_flag | input | 1 | Current single-step flag |
| insn_retire | input | 1 | An instruction completes this cycle |
| bp_trap | output | 1 | Breakpoint trap pulse |
| step_trap | output | 1 | Single-step trap pulse |

## Verification
A match or a step trap sampled at a clock edge shows on `bp_trap` or `step_trap` one edge later, together with its status bit. Register reads are combinational on the select, so a written value is visible from the cycle after the write edge. The bench drives inputs on falling edges. It compares a behavioural model against the outputs 1 ns after each rising edge, and its directed checks sample at the next falling edge. Every expected value is therefore taken after exactly one register stage.

// File: rtl/bkpt_pkg.sv
// Shared definitions for the breakpoint match unit.
// Assumes a 32-bit register word and the select map used by the top level.
package bkpt_pkg;

    typedef enum logic [1:0] {
        AK_FETCH = 2'b00,
        AK_READ  = 2'b01,
        AK_WRITE = 2'b10,
        AK_PORT  = 2'b11
    } acc_kind_e;

    localparam int          REG_W      = 32;
    localparam logic [2:0]  SEL_STATUS = 3'd4;
    localparam logic [2:0]  SEL_CTRL   = 3'd5;
    localparam int          STEP_BIT   = 14;
    localparam int          TYPE_LSB   = 16;
    localparam int          LEN_LSB    = 18;
    localparam int          FIELD_STEP = 4;

endpackage

// File: rtl/bkpt_slot.sv
// One breakpoint comparator slot.
// Decides combinationally whether the presented access hits this slot.
// Assumes the caller has already merged the local and global enables.
module bkpt_slot
    import bkpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] slot_addr,
    input  logic          enable,
    input  logic [1:0]    rw_type,
    input  logic [1:0]    len_code,
    input  logic          dbg_ext,
    input  logic          resume_flag,
    input  logic          acc_valid,
    input  logic [1:0]    acc_kind,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    output logic          hit
);

    logic [AW-1:0] len_mask;
    logic [AW-1:0] acc_ext;
    logic [AW-1:0] base;
    logic [AW-1:0] slot_end;
    logic [AW:0]   acc_end;
    logic          type_ok;
    logic          overlap;
    acc_kind_e     kind;

    // Turn the length and size codes into byte-offset masks.
    always_comb begin
        case (len_code)
            2'b00:   len_mask = '0;
            2'b01:   len_mask = AW'(1);
            default: len_mask = AW'(3);
        endcase
        case (acc_size)
            2'b00:   acc_ext = '0;
            2'b01:   acc_ext = AW'(1);
            default: acc_ext = AW'(3);
        endcase
    end

    // Compare the aligned slot range with the access byte range, without wrap.
    always_comb begin
        base     = slot_addr & ~len_mask;
        slot_end = base | len_mask;
        acc_end  = {1'b0, acc_addr} + {1'b0, acc_ext};
        overlap  = (acc_addr <= slot_end) && ({1'b0, base} <= acc_end);
    end

    // Check that the access kind is one this slot's type code accepts.
    always_comb begin
        kind = acc_kind_e'(acc_kind);
        case (rw_type)
            2'b00:   type_ok = (kind == AK_FETCH) && !resume_flag;
            2'b01:   type_ok = (kind == AK_WRITE);
            2'b11:   type_ok = (kind == AK_READ) || (kind == AK_WRITE);
            default: type_ok = dbg_ext && (kind == AK_PORT);
        endcase
    end

    // Final qualification of the match.
    always_comb begin
        hit = acc_valid && enable && type_ok && (len_code != 2'b10) && overlap;
    end

endmodule

// File: rtl/bkpt_step.sv
// Single-step trap tracker.
// Traps at each retire whose instruction began with the trap flag set.
// Assumes trap_flag shows the flag value after the retiring instruction.
module bkpt_step (
    input  logic clk,
    input  logic rst_n,
    input  logic trap_flag,
    input  logic insn_retire,
    output logic step_now,
    output logic step_trap
);

    logic armed_q;

    // A retire traps when the flag was already set at the previous retire.
    always_comb begin
        step_now = insn_retire && armed_q;
    end

    // Track the flag at each retire and register the trap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            step_trap <= 1'b0;
        end else begin
            step_trap <= step_now;
            if (insn_retire) begin
                armed_q <= trap_flag;
            end
        end
    end

    p_step_after_retire_r12: assert property (@(posedge clk) disable iff (!rst_n)
        step_trap |-> $past(insn_retire));

    p_step_one_late_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_retire && !armed_q) |=> !step_trap);

endmodule

// File: rtl/bkpt_match_unit.sv
// Breakpoint match unit top level.
// Holds the address, control and status registers, runs the slot
// comparators and the single-step tracker, and registers the trap pulses.
// Assumes one access and at most one retire per cycle.
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NUM_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [AW-1:0]     acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              dbg_ext,
    input  logic              resume_flag,
    input  logic              trap_flag,
    input  logic              insn_retire,
    output logic              bp_trap,
    output logic              step_trap
);

    localparam logic [REG_W-1:0] STATUS_ONES = 32'hFFFF_0000;

    logic [AW-1:0]        addr_q [NUM_SLOTS];
    logic [REG_W-1:0]     ctrl_q;
    logic [NUM_SLOTS-1:0] st_bits_q;
    logic                 bs_q;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 step_now;
    logic                 st_wr;

    // One comparator per slot, with its fields taken from the control word.
    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        bkpt_slot #(.AW(AW)) u_slot (
            .slot_addr  (addr_q[n]),
            .enable     (ctrl_q[2*n] | ctrl_q[2*n+1]),
            .rw_type    (ctrl_q[TYPE_LSB + FIELD_STEP*n +: 2]),
            .len_code   (ctrl_q[LEN_LSB + FIELD_STEP*n +: 2]),
            .dbg_ext    (dbg_ext),
            .resume_flag(resume_flag),
            .acc_valid  (acc_valid),
            .acc_kind   (acc_kind),
            .acc_addr   (acc_addr),
            .acc_size   (acc_size),
            .hit        (slot_hit[n])
        );

        p_len_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[LEN_LSB + FIELD_STEP*n +: 2] == 2'b10) |-> !slot_hit[n]);

        p_type_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((ctrl_q[TYPE_LSB + FIELD_STEP*n +: 2] == 2'b10) && !dbg_ext) |-> !slot_hit[n]);

        p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[2*n +: 2] == 2'b00) |-> !slot_hit[n]);
    end

    bkpt_step u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_flag  (trap_flag),
        .insn_retire(insn_retire),
        .step_now   (step_now),
        .step_trap  (step_trap)
    );

    // Decode a software write to the status word.
    always_comb begin
        st_wr = reg_we && (reg_sel == SEL_STATUS);
    end

    // Register file updates, sticky status and the breakpoint trap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                addr_q[n] <= '0;
            end
            ctrl_q    <= '0;
            st_bits_q <= '0;
            bs_q      <= 1'b0;
            bp_trap   <= 1'b0;
        end else begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                if (reg_we && (reg_sel == 3'(n))) begin
                    addr_q[n] <= reg_wdata[AW-1:0];
                end
            end
            if (reg_we && (reg_sel == SEL_CTRL)) begin
                ctrl_q <= reg_wdata;
            end
            if (st_wr) begin
                st_bits_q <= reg_wdata[NUM_SLOTS-1:0] | slot_hit;
                bs_q      <= reg_wdata[STEP_BIT] | step_now;
            end else begin
                st_bits_q <= st_bits_q | slot_hit;
                bs_q      <= bs_q | step_now;
            end
            bp_trap <= |slot_hit;
        end
    end

    // Combinational read mux over the register set.
    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < NUM_SLOTS; n++) begin
            if (reg_sel == 3'(n)) begin
                reg_rdata = REG_W'(addr_q[n]);
            end
        end
        if (reg_sel == SEL_CTRL) begin
            reg_rdata = ctrl_q;
        end
        if (reg_sel == SEL_STATUS) begin
            reg_rdata                  = STATUS_ONES;
            reg_rdata[STEP_BIT]        = bs_q;
            reg_rdata[NUM_SLOTS-1:0]   = st_bits_q;
        end
    end

    p_trap_has_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bp_trap |-> (st_bits_q != '0));

    p_no_valid_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !bp_trap);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((st_bits_q & $past(st_bits_q)) == $past(st_bits_q)));

    p_resume_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_flag && (acc_kind == 2'b00)) |-> (slot_hit == '0));

endmodule

// File: tb/sim_bkpt_match_unit.sv
`timescale 1ns/1ps
module sim_bkpt_match_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [31:0] acc_addr = 32'd0;
    logic [1:0]  acc_size = 2'd0;
    logic        dbg_ext = 1'b0;
    logic        resume_flag = 1'b0;
    logic        trap_flag = 1'b0;
    logic        insn_retire = 1'b0;
    logic        bp_trap;
    logic        step_trap;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    bkpt_match_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size),
        .dbg_ext(dbg_ext), .resume_flag(resume_flag), .trap_flag(trap_flag),
        .insn_retire(insn_retire), .bp_trap(bp_trap), .step_trap(step_trap)
    );

    // Reference model state
    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl;
    logic [3:0]  m_bits;
    logic        m_bs, m_armed, m_bp, m_step;

    function automatic bit m_hit(int n);
        longint blen, slen, base, a;
        logic [1:0] ty, ln;
        bit ok;
        if (!acc_valid) return 0;
        if (!(m_ctrl[2*n] || m_ctrl[2*n+1])) return 0;
        ty = m_ctrl[16+4*n +: 2];
        ln = m_ctrl[18+4*n +: 2];
        if (ln == 2'b10) return 0;
        blen = (ln == 2'b00) ? 1 : (ln == 2'b01) ? 2 : 4;
        slen = (acc_size == 2'b00) ? 1 : (acc_size == 2'b01) ? 2 : 4;
        base = longint'(m_addr[n]) - (longint'(m_addr[n]) % blen);
        a = longint'(acc_addr);
        case (ty)
            2'b00: ok = (acc_kind == 2'b00) && !resume_flag;
            2'b01: ok = (acc_kind == 2'b10);
            2'b11: ok = (acc_kind == 2'b01) || (acc_kind == 2'b10);
            default: ok = dbg_ext && (acc_kind == 2'b11);
        endcase
        return ok && (a < base + blen) && (base < a + slen);
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] s);
        logic [31:0] v;
        if (s < 3'd4) v = m_addr[s[1:0]];
        else if (s == 3'd4) begin
            v = 32'hFFFF_0000;
            v[14] = m_bs;
            v[3:0] = m_bits;
        end else if (s == 3'd5) v = m_ctrl;
        else v = 32'd0;
        return v;
    endfunction

    // Model update on each rising edge
    always @(posedge clk) begin
        logic [3:0] h;
        bit sn;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_addr[i] <= 32'd0;
            m_ctrl <= 0; m_bits <= 0; m_bs <= 0; m_armed <= 0; m_bp <= 0; m_step <= 0;
        end else begin
            for (int i = 0; i < 4; i++) h[i] = m_hit(i);
            sn = insn_retire && m_armed;
            m_bp <= (h != 0);
            m_step <= sn;
            if (insn_retire) m_armed <= trap_flag;
            if (reg_we && reg_sel < 3'd4) m_addr[reg_sel[1:0]] <= reg_wdata;
            if (reg_we && reg_sel == 3'd5) m_ctrl <= reg_wdata;
            if (reg_we && reg_sel == 3'd4) begin
                m_bits <= reg_wdata[3:0] | h;
                m_bs <= reg_wdata[14] | sn;
            end else begin
                m_bits <= m_bits | h;
                m_bs <= m_bs | sn;
            end
        end
        started <= 1;
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison with the model
    always @(posedge clk) begin
        #1;
        if (started && !done) begin
            check("R9 model bp_trap", {31'd0, bp_trap}, {31'd0, m_bp});
            check("R12 model step_trap", {31'd0, step_trap}, {31'd0, m_step});
            check("R2 model reg_rdata", reg_rdata, m_read(reg_sel));
        end
    end

    task automatic wr(logic [2:0] s, logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(logic [2:0] s, logic [31:0] exp, string tag);
        @(negedge clk); reg_sel = s;
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic acc(bit v, logic [1:0] k, logic [31:0] a, logic [1:0] sz, bit exp, string tag);
        @(negedge clk); acc_valid = v; acc_kind = k; acc_addr = a; acc_size = sz;
        @(negedge clk); check(tag, {31'd0, bp_trap}, {31'd0, exp});
        acc_valid = 0;
    endtask

    task automatic retire(bit exp, string tag);
        @(negedge clk); insn_retire = 1;
        @(negedge clk); check(tag, {31'd0, step_trap}, {31'd0, exp});
        insn_retire = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 addr0 after reset");
        rd(3'd4, 32'hFFFF_0000, "R1 status after reset");
        rd(3'd5, 32'h0, "R1 ctrl after reset");
        check("R1 bp_trap after reset", {31'd0, bp_trap}, 32'd0);
        check("R1 step_trap after reset", {31'd0, step_trap}, 32'd0);
        rd(3'd6, 32'h0, "R2 unused select");
        // R2 readback
        wr(3'd0, 32'h0000_1000);
        wr(3'd5, 32'h0000_0001);
        rd(3'd0, 32'h0000_1000, "R2 addr0 readback");
        rd(3'd5, 32'h0000_0001, "R2 ctrl readback");
        // R4 fetch type, R9 pulse and status
        acc(1, 2'b00, 32'h1000, 2'b00, 1, "R4 fetch hit");
        @(negedge clk); check("R9 pulse one cycle", {31'd0, bp_trap}, 32'd0);
        rd(3'd4, 32'hFFFF_0001, "R9 status bit0 set");
        wr(3'd4, 32'h0);
        rd(3'd4, 32'hFFFF_0000, "R10 software clear");
        acc(1, 2'b01, 32'h1000, 2'b00, 0, "R4 read vs fetch slot");
        acc(1, 2'b00, 32'h1001, 2'b00, 0, "R6 one byte outside");
        // R4 write-only type
        wr(3'd5, 32'h0001_0001);
        acc(1, 2'b10, 32'h1000, 2'b00, 1, "R4 write hit");
        acc(1, 2'b01, 32'h1000, 2'b00, 0, "R4 read vs write slot");
        acc(1, 2'b00, 32'h1000, 2'b00, 0, "R4 fetch vs write slot");
        // R6, R7 four-byte read/write slot
        wr(3'd5, 32'h000F_0001);
        wr(3'd0, 32'h0000_2003);
        acc(1, 2'b01, 32'h2000, 2'b00, 1, "R6 aligned base hit");
        acc(1, 2'b01, 32'h2004, 2'b00, 0, "R6 past end");
        acc(1, 2'b10, 32'h1FFE, 2'b11, 1, "R7 overlap from below");
        acc(1, 2'b01, 32'h1FFC, 2'b11, 0, "R7 adjacent below");
        acc(1, 2'b10, 32'h1FFF, 2'b01, 1, "R7 two byte overlap");
        acc(1, 2'b00, 32'h2001, 2'b00, 0, "R4 fetch vs data slot");
        wr(3'd5, 32'h000B_0001);
        acc(1, 2'b01, 32'h2000, 2'b00, 0, "R6 undefined length");
        // R5 port type
        wr(3'd5, 32'h0002_0001);
        acc(1, 2'b11, 32'h2003, 2'b00, 0, "R5 port without ext");
        dbg_ext = 1;
        acc(1, 2'b11, 32'h2003, 2'b00, 1, "R5 port with ext");
        acc(1, 2'b01, 32'h2003, 2'b00, 0, "R5 read vs port slot");
        dbg_ext = 0;
        // R3 enables
        wr(3'd0, 32'h0000_1000);
        wr(3'd5, 32'h0000_0002);
        acc(1, 2'b00, 32'h1000, 2'b00, 1, "R3 global enable");
        wr(3'd5, 32'h0000_0000);
        acc(1, 2'b00, 32'h1000, 2'b00, 0, "R3 disabled");
        // R8 valid gating
        wr(3'd5, 32'h0000_0001);
        acc(0, 2'b00, 32'h1000, 2'b00, 0, "R8 no valid");
        // R11 resume
        resume_flag = 1;
        acc(1, 2'b00, 32'h1000, 2'b00, 0, "R11 fetch masked");
        wr(3'd5, 32'h000F_0001);
        acc(1, 2'b01, 32'h1000, 2'b00, 1, "R11 data unaffected");
        resume_flag = 0;
        // R10 sticky
        wr(3'd4, 32'h0);
        acc(1, 2'b01, 32'h5000, 2'b00, 0, "R10 miss");
        rd(3'd4, 32'hFFFF_0000, "R10 stays clear");
        acc(1, 2'b01, 32'h1000, 2'b00, 1, "R10 hit");
        acc(1, 2'b01, 32'h5000, 2'b00, 0, "R10 miss after hit");
        rd(3'd4, 32'hFFFF_0001, "R10 sticky bit");
        @(negedge clk); reg_we = 1; reg_sel = 3'd4; reg_wdata = 0;
        acc_valid = 1; acc_kind = 2'b01; acc_addr = 32'h1000; acc_size = 0;
        @(negedge clk); reg_we = 0; acc_valid = 0;
        rd(3'd4, 32'hFFFF_0001, "R10 hit wins over write");
        // R9 multiple slots
        wr(3'd4, 32'h0);
        wr(3'd1, 32'h0000_3000);
        wr(3'd2, 32'h0000_3000);
        wr(3'd5, 32'h0330_0014);
        acc(1, 2'b01, 32'h3000, 2'b00, 1, "R9 two slots hit");
        rd(3'd4, 32'hFFFF_0006, "R9 both status bits");
        // R13 fixed status bits
        wr(3'd4, 32'h0000_BFF0);
        rd(3'd4, 32'hFFFF_0000, "R13 unimplemented bits");
        // R12 single step
        trap_flag = 1;
        retire(0, "R12 no trap on setting instruction");
        retire(1, "R12 trap on next instruction");
        rd(3'd4, 32'hFFFF_4000, "R12 step status bit");
        trap_flag = 0;
        retire(1, "R12 trap when flag cleared by instruction");
        retire(0, "R12 no trap after clear");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule